// File: doc/BRIEF.md
# Three-Way Set Dueling Policy Selector

This block decides which of three candidate cache management policies each cache set should follow. A small, fixed sample of sets is dedicated to each candidate. Demand misses in those sample sets are scored on one saturating counter per candidate. The candidates are:

- static insertion with prefetch hits left unpromoted;
- static insertion with prefetch hits left unpromoted and prefetch fills placed at the distant end;
- bimodal insertion with prefetch hits left unpromoted.

Every set outside the samples copies the candidate whose counter is currently lowest.

The surrounding cache presents the index of the set being accessed, a miss strobe and the kind of request. It receives back the policy code that set must use for its insertion and hit update. Sample sets always report their own candidate. Tag lookup, replacement state and the prefetcher sit outside this block.

Top module: `sdm3_policy_select`

## Requirements
- R1: With the set index split into a high field (the top log2(MON_SETS) bits) and a low field (the bottom log2(MON_SETS) bits), membership is decided by high XOR low. A result of all zeros marks a group-0 sample set, all ones a group-1 sample set, and the alternating pattern with bit 0 set (10101 for 5-bit fields) a group-2 sample set. Any other result marks a follower. With the defaults, each group holds 32 sets and no set belongs to two groups. A sample set outputs its own group's code.
- R2: policy_sel encodes 0 = static insertion / hit-only prefetch handling, 1 = static insertion / hit-and-miss prefetch handling, 2 = bimodal insertion / hit-only prefetch handling. The value 3 never appears.
- R3: A miss with req_kind = 0 (demand) in a sample set of group g adds 2 to counter g and subtracts 1 from each of the other two counters, all on the same clock edge.
- R4: If counter g is above its maximum minus 2, a demand miss in group g changes no counter.
- R5: If either of the other two counters is zero, a demand miss in group g changes no counter.
- R6: Misses with req_kind = 1 (prefetch), 2 (writeback) or 3, demand misses in follower sets, and cycles without miss_valid change no counter.
- R7: A follower set outputs the code of the smallest counter. Ties go to code 0, then 1, then 2.
- R8: Reset (rst_n low, asynchronous) puts all three counters at mid-scale (512 for 10-bit counters), so every follower outputs 0.
- R9: policy_sel is combinational in set_idx. A counter update made at a clock edge is visible on policy_sel for follower sets from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_idx | input | IDX_W | Index of the set being accessed |
| miss_valid | input | 1 | The access missed in the cache this cycle |
| req_kind | input | 2 | Request kind: 0 demand, 1 prefetch, 2 writeback |
| policy_sel | output | 2 | Policy code the indexed set must follow |

## Verification
policy_sel depends combinationally on set_idx and on the counters, so each result is due in the same cycle as the index that produces it. A miss, however, only moves the counters at the next rising edge. The bench therefore drives each access just after a falling edge and compares policy_sel a moment later, against a model holding the counters as they stood before that edge. It then advances its model at the rising edge, so the next comparison sees the effect of the update one cycle after the miss. The saturation freezes and the ignored request kinds are observed through follower sets, whose output would move if a counter had changed.

// File: rtl/sdm3_pkg.sv
package sdm3_pkg;

   localparam int NPOL = 3;

   typedef enum logic [1:0] {
      POL_STATIC_HIT   = 2'd0,
      POL_STATIC_HITMS = 2'd1,
      POL_BIMODAL_HIT  = 2'd2
   } pol_e;

   typedef enum logic [1:0] {
      REQ_DEMAND    = 2'd0,
      REQ_PREFETCH  = 2'd1,
      REQ_WRITEBACK = 2'd2
   } req_e;

   // XOR key that marks a sample set of group g, for a field of width w
   function automatic logic [31:0] group_key(input int g, input int w);
      logic [31:0] k;
      k = '0;
      for (int i = 0; i < w; i++) begin
         case (g)
            0:       k[i] = 1'b0;
            1:       k[i] = 1'b1;
            default: k[i] = (i % 2 == 0);
         endcase
      end
      return k;
   endfunction

endpackage

// File: rtl/sdm3_member_dec.sv
module sdm3_member_dec
   import sdm3_pkg::*;
#(
   parameter int IDX_W = 10,
   parameter int GRP_W = 5
) (
   input  logic [IDX_W-1:0] idx,
   output logic [NPOL-1:0]  mon_oh
);

   logic [GRP_W-1:0] hi_f;
   logic [GRP_W-1:0] lo_f;
   logic [GRP_W-1:0] diff;

   assign hi_f = idx[IDX_W-1 -: GRP_W];
   assign lo_f = idx[GRP_W-1:0];
   assign diff = hi_f ^ lo_f;

   for (genvar g = 0; g < NPOL; g++) begin : g_key
      localparam logic [31:0] KEY_FULL = group_key(g, GRP_W);
      localparam logic [GRP_W-1:0] KEY = KEY_FULL[GRP_W-1:0];
      assign mon_oh[g] = (diff == KEY);
   end

endmodule

// File: rtl/sdm3_cnt_bank.sv
module sdm3_cnt_bank
   import sdm3_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int UP_STEP = 2,
   parameter int DN_STEP = 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           upd_req,
   input  logic [NPOL-1:0]                upd_oh,
   output logic [NPOL-1:0][CNT_W-1:0]     cnt_q
);

   localparam logic [CNT_W-1:0] CNT_MAX   = '1;
   localparam logic [CNT_W-1:0] CNT_MID   = {1'b1, {(CNT_W-1){1'b0}}};
   localparam logic [CNT_W-1:0] UP_V      = CNT_W'(UP_STEP);
   localparam logic [CNT_W-1:0] DN_V      = CNT_W'(DN_STEP);
   localparam logic [CNT_W-1:0] TOP_LIMIT = CNT_MAX - UP_V;

   logic [NPOL-1:0] top_sat;
   logic [NPOL-1:0] bot_sat;
   logic            blocked;
   logic            apply;

   for (genvar g = 0; g < NPOL; g++) begin : g_sat
      assign top_sat[g] = cnt_q[g] > TOP_LIMIT;
      assign bot_sat[g] = cnt_q[g] < DN_V;
   end

   // all-or-nothing: any bound hit by any participant freezes the bank
   assign blocked = |(upd_oh & top_sat) | |(~upd_oh & bot_sat);
   assign apply   = upd_req & ~blocked;

   for (genvar g = 0; g < NPOL; g++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q[g] <= CNT_MID;
         end else if (apply) begin
            if (upd_oh[g]) cnt_q[g] <= cnt_q[g] + UP_V;
            else           cnt_q[g] <= cnt_q[g] - DN_V;
         end
      end
   end

endmodule

// File: rtl/sdm3_min_pick.sv
module sdm3_min_pick
   import sdm3_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic [NPOL-1:0][CNT_W-1:0] cnt,
   output logic [1:0]                 pick
);

   logic [CNT_W-1:0] best;

   // strict compare keeps the lower index on ties
   always_comb begin
      pick = 2'd0;
      best = cnt[0];
      for (int g = 1; g < NPOL; g++) begin
         if (cnt[g] < best) begin
            best = cnt[g];
            pick = 2'(g);
         end
      end
   end

endmodule

// File: rtl/sdm3_policy_select.sv
module sdm3_policy_select
   import sdm3_pkg::*;
#(
   parameter int IDX_W    = 10,
   parameter int MON_SETS = 32,
   parameter int CNT_W    = 10,
   parameter int UP_STEP  = 2,
   parameter int DN_STEP  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             miss_valid,
   input  logic [1:0]       req_kind,
   output logic [1:0]       policy_sel
);

   localparam int GRP_W = $clog2(MON_SETS);

   if (IDX_W < 2 * GRP_W) begin : g_chk_idx
      $error("set index too narrow for the sample groups");
   end
   if ((1 << GRP_W) != MON_SETS || GRP_W < 2) begin : g_chk_mon
      $error("MON_SETS must be a power of two, at least 4");
   end
   if (CNT_W < 3 || UP_STEP < 1 || DN_STEP < 1 || UP_STEP >= (1 << (CNT_W-1))) begin : g_chk_cnt
      $error("counter width or steps out of range");
   end

   logic [NPOL-1:0]            mon_oh;
   logic [NPOL-1:0][CNT_W-1:0] cnt_q;
   logic [1:0]                 min_code;
   logic [1:0]                 mon_code;
   logic                       is_demand;
   logic                       upd_req;

   sdm3_member_dec #(.IDX_W(IDX_W), .GRP_W(GRP_W)) dec_i (
      .idx    (set_idx),
      .mon_oh (mon_oh)
   );

   assign is_demand = (req_kind == REQ_DEMAND);
   assign upd_req   = miss_valid & is_demand & (|mon_oh);

   sdm3_cnt_bank #(.CNT_W(CNT_W), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_req (upd_req),
      .upd_oh  (mon_oh),
      .cnt_q   (cnt_q)
   );

   sdm3_min_pick #(.CNT_W(CNT_W)) pick_i (
      .cnt  (cnt_q),
      .pick (min_code)
   );

   always_comb begin
      mon_code = 2'd0;
      for (int g = 0; g < NPOL; g++) begin
         if (mon_oh[g]) mon_code = 2'(g);
      end
   end

   assign policy_sel = (|mon_oh) ? mon_code : min_code;

endmodule

// File: rtl/sdm3_policy_select_chk.sv
module sdm3_policy_select_chk
   import sdm3_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int UP_STEP = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       miss_valid,
   input logic [1:0]                 req_kind,
   input logic [NPOL-1:0]            mon_oh,
   input logic [NPOL-1:0][CNT_W-1:0] cnt_q,
   input logic [1:0]                 policy_sel
);

   localparam logic [CNT_W-1:0] LIM = '1 - CNT_W'(UP_STEP);

   logic dem_miss;
   assign dem_miss = miss_valid && (req_kind == 2'd0);

   assert_one_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mon_oh));

   assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      policy_sel != 2'd3);

   for (genvar g = 0; g < NPOL; g++) begin : g_upd
      localparam int O1 = (g + 1) % NPOL;
      localparam int O2 = (g + 2) % NPOL;

      assert_plus_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (dem_miss && mon_oh[g] && cnt_q[g] <= LIM && cnt_q[O1] != '0 && cnt_q[O2] != '0)
         |=> (cnt_q[g] == $past(cnt_q[g]) + CNT_W'(UP_STEP)) && (cnt_q[O1] < $past(cnt_q[O1])));

      assert_top_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (dem_miss && mon_oh[g] && cnt_q[g] > LIM) |=> $stable(cnt_q));

      assert_zero_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (dem_miss && mon_oh[g] && (cnt_q[O1] == '0 || cnt_q[O2] == '0)) |=> $stable(cnt_q));
   end

   assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!miss_valid || req_kind != 2'd0 || mon_oh == '0) |=> $stable(cnt_q));

   assert_min_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_oh == '0 && policy_sel < 2'd3) |->
         (cnt_q[policy_sel] <= cnt_q[0] && cnt_q[policy_sel] <= cnt_q[1] && cnt_q[policy_sel] <= cnt_q[2]));

endmodule

bind sdm3_policy_select sdm3_policy_select_chk #(.CNT_W(CNT_W), .UP_STEP(UP_STEP)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .miss_valid (miss_valid),
   .req_kind   (req_kind),
   .mon_oh     (mon_oh),
   .cnt_q      (cnt_q),
   .policy_sel (policy_sel)
);

// File: tb/sdm3_policy_select_tb_top.sv
module sdm3_policy_select_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int IDX_W = 10;
   localparam int CMAX  = 1023;
   localparam int CMID  = 512;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [IDX_W-1:0] set_idx = '0;
   logic             miss_valid = 1'b0;
   logic [1:0]       req_kind = 2'd0;
   logic [1:0]       policy_sel;

   int n_cmp = 0;
   int n_bad = 0;
   int mcnt [3];
   bit finished = 0;

   sdm3_policy_select dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_idx    (set_idx),
      .miss_valid (miss_valid),
      .req_kind   (req_kind),
      .policy_sel (policy_sel)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int key_of(input int g);
      return (g == 0) ? 0 : (g == 1) ? 31 : 21;
   endfunction

   function automatic int grp_of(input int idx);
      int d;
      d = ((idx >> 5) & 31) ^ (idx & 31);
      for (int g = 0; g < 3; g++) if (d == key_of(g)) return g;
      return -1;
   endfunction

   function automatic int mon_idx(input int g, input int hi);
      return ((hi & 31) << 5) | ((hi ^ key_of(g)) & 31);
   endfunction

   function automatic int exp_pol(input int idx);
      int g, b;
      g = grp_of(idx);
      if (g >= 0) return g;
      b = 0;
      for (int k = 1; k < 3; k++) if (mcnt[k] < mcnt[b]) b = k;
      return b;
   endfunction

   function automatic void model_upd(input int idx, input bit mv, input int kind);
      int g;
      g = grp_of(idx);
      if (!mv || kind != 0 || g < 0) return;
      if (mcnt[g] > CMAX - 2) return;
      for (int k = 0; k < 3; k++) if (k != g && mcnt[k] == 0) return;
      for (int k = 0; k < 3; k++) mcnt[k] = (k == g) ? mcnt[k] + 2 : mcnt[k] - 1;
   endfunction

   task automatic check_pol(input string tag, input int idx);
      int e;
      e = exp_pol(idx);
      n_cmp++;
      if (int'(policy_sel) != e) begin
         n_bad++;
         $display("FAIL %s idx=%0d actual=%0d expected=%0d", tag, idx, policy_sel, e);
      end
   endtask

   task automatic step(input int idx, input bit mv, input int kind, input string tag);
      @(negedge clk);
      set_idx    = idx[IDX_W-1:0];
      miss_valid = mv;
      req_kind   = 2'(kind);
      #1;
      check_pol(tag, idx);
      @(posedge clk);
      model_upd(idx, mv, kind);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      miss_valid = 1'b0;
      repeat (3) @(negedge clk);
      for (int k = 0; k < 3; k++) mcnt[k] = CMID;
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      do_reset();

      // R8: reset state, follower picks code 0
      step(5, 0, 0, "R8 reset follower");
      // R1: sample sets report their own group code
      for (int g = 0; g < 3; g++) step(mon_idx(g, 3), 0, 0, "R1 sample set code");
      step(mon_idx(2, 17), 0, 0, "R1 sample set code");

      // R6: prefetch/writeback/kind 3 misses in group 0 are ignored
      for (int i = 0; i < 10; i++) step(mon_idx(0, i), 1, 1 + (i % 3), "R6 non-demand");
      for (int i = 0; i < 10; i++) step(7 + i, 1, 0, "R6 follower demand");
      step(5, 0, 0, "R6 follower unchanged");

      // R7: tie after one group-2 demand miss goes to code 0
      step(mon_idx(2, 4), 1, 0, "R3 group2 miss");
      step(5, 0, 0, "R7 tie order");
      // R3/R9: a group-0 miss, visible to followers next cycle
      step(mon_idx(0, 4), 1, 0, "R3 group0 miss");
      step(5, 0, 0, "R9 next cycle");
      step(mon_idx(0, 9), 1, 0, "R3 group0 miss");
      step(6, 0, 0, "R9 next cycle");

      // R4: drive group 2 to its top bound
      do_reset();
      for (int i = 0; i < 300; i++) step(mon_idx(2, i), 1, 0, "R4 top freeze");
      for (int i = 0; i < 4; i++) step(mon_idx(1, i), 1, 0, "R4 after top");
      step(5, 0, 0, "R4 follower");

      // R5: alternate groups 0 and 1 until group 2 hits zero
      do_reset();
      for (int i = 0; i < 600; i++) step(mon_idx(i % 2, i), 1, 0, "R5 zero freeze");
      step(5, 0, 0, "R5 follower");
      step(mon_idx(2, 1), 1, 0, "R5 group2 recovers");
      step(5, 0, 0, "R5 follower");

      // R2/R3/R7 random mix
      do_reset();
      for (int i = 0; i < 6000; i++) begin
         int r, idx;
         r = $urandom % 4;
         if (r < 3) idx = mon_idx(r, $urandom % 32);
         else       idx = $urandom % 1024;
         step(idx, ($urandom % 4) != 0, ($urandom % 5 < 3) ? 0 : ($urandom % 4), "R2 R7 random");
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule